// File: doc/BRIEF.md
# Wakeup Frame Pattern Matcher

This block sits on the receive byte stream of an Ethernet controller while the host sleeps. It looks for up to eight programmed wakeup patterns. Each pattern selects bytes of the frame through a 64-bit byte mask. The mask covers a fixed window that starts twelve bytes into the frame, just after the two MAC addresses. The block folds the selected bytes of each pattern into its own CRC-8 accumulator. When the frame ends, it compares every accumulator with that pattern's stored reference.

Software writes the masks and references through a narrow byte-wide write port before the host goes to sleep. At the end of each good frame, the block reports a per-pattern match vector. It also raises one wake pulse when any pattern matched and waking is enabled. All eight patterns are evaluated in parallel on every received byte, so frames can arrive back to back without any stall.

Top module: `wkp_matcher`

## Requirements
- R1: After a synchronous active-low reset, `match_o` is all zeros and `wake_o` is low, and every mask and reference register reads as zero.
- R2: For each pattern, the CRC is CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0x00, input bytes processed MSB first, with no reflection and no final XOR. It is updated only on bytes whose mask bit is 1. A pattern matches when the result equals its 8-bit reference.
- R3: Mask bit k selects frame byte offset 12+k, for k = 0 to 63, where byte offset 0 is the byte that carries `rx_sof`. Bytes at offsets 0 to 11, and from offset 76 onward, never affect any result.
- R4: Write port map. `cfg_addr[6:4]` selects the pattern. For `cfg_addr[3:0]` = n with n from 0 to 7, the write goes to mask bits [8n+7:8n]. Index 8 writes the reference. Index 9 is a second path to mask bits [7:0]. Indices 10 to 15 change nothing.
- R5: A pattern whose mask is all zeros never matches, even when its reference equals the initial CRC value.
- R6: No pattern matches on a frame whose `rx_good` is low on its end byte.
- R7: A frame that ends before offset 75 is judged only on the masked bytes it actually delivered.
- R8: The eight patterns are independent. Bit i of `match_o` reports pattern i only.
- R9: `wake_o` is the OR of the matches of one frame end, gated by `wake_en`. `match_o` is reported whatever the state of `wake_en`.
- R10: A byte with `rx_sof` restarts the byte offset and every accumulator, even if the previous frame never delivered an end byte.
- R11: `match_o` and `wake_o` are valid in the cycle after the end byte is accepted, and they last exactly one cycle when the next cycle carries no end byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_en | input | 1 | Global enable for the wake pulse |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | This byte is frame offset 0 |
| rx_eof | input | 1 | This byte is the last byte of the frame |
| rx_good | input | 1 | Frame passed its checks, read together with the end byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Pattern number in bits [6:4], register index in bits [3:0] |
| cfg_wdata | input | 8 | Register write data |
| match_o | output | 8 | One-cycle match flags, one per pattern |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
Four properties are checked on every cycle. A wake pulse is always backed by at least one match flag, and by an enable that was high one cycle earlier. Any match flag follows an accepted good end byte. A pattern with an all-zero mask never raises its flag. Only the directed scenarios can show that the CRC value, the window alignment at offset 12, the register aliasing, short-frame handling and the restart on a new start byte are right. Each of those needs a reference CRC computed from the frame contents and compared with the match vector.

// File: rtl/wkp_pkg.sv
// Shared types and the CRC-8 byte step used by all pattern lanes.
// Assumes MSB-first bit order with no reflection.
package wkp_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // One CRC-8 update over a full byte, MSB first.
    function automatic byte_t crc8_step(input byte_t crc_in, input byte_t din, input byte_t poly);
        byte_t c;
        c = crc_in ^ din;
        for (int b = 0; b < BYTE_W; b++) begin
            c = c[BYTE_W-1] ? byte_t'((c << 1) ^ poly) : byte_t'(c << 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/wkp_cfg_regs.sv
// Mask and reference storage for all patterns.
// Assumes cfg_addr = {pattern, index[3:0]}; index MBYTES writes the
// reference, MBYTES+1 aliases mask byte 0, higher indices are ignored.
module wkp_cfg_regs
    import wkp_pkg::*;
#(
    parameter int NUM_PAT = 8,
    parameter int MASK_W  = 64,
    parameter int ADDR_W  = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  byte_t                         cfg_wdata,
    output logic [NUM_PAT-1:0][MASK_W-1:0] mask_o,
    output byte_t [NUM_PAT-1:0]           ref_o
);
    localparam int MBYTES   = MASK_W / BYTE_W;
    localparam int IDX_REF  = MBYTES;
    localparam int IDX_LOW  = MBYTES + 1;

    logic [ADDR_W-5:0] sel_pat;
    logic [3:0]        sel_idx;

    assign sel_pat = cfg_addr[ADDR_W-1:4];
    assign sel_idx = cfg_addr[3:0];

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
        logic [MASK_W-1:0] mask_q;
        byte_t             ref_q;

        // Capture writes aimed at this pattern.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
                ref_q  <= '0;
            end else if (cfg_we && (int'(sel_pat) == g)) begin
                if (int'(sel_idx) < MBYTES) begin
                    mask_q[int'(sel_idx)*BYTE_W +: BYTE_W] <= cfg_wdata;
                end else if (int'(sel_idx) == IDX_REF) begin
                    ref_q <= cfg_wdata;
                end else if (int'(sel_idx) == IDX_LOW) begin
                    mask_q[BYTE_W-1:0] <= cfg_wdata;
                end
            end
        end

        assign mask_o[g] = mask_q;
        assign ref_o[g]  = ref_q;
    end
endmodule

// File: rtl/wkp_offset.sv
// Byte offset tracker for the receive stream.
// Tells whether the current byte falls in the mask window and which mask
// bit covers it. Assumes rx_sof marks offset 0. The count saturates past
// the window end.
module wkp_offset #(
    parameter int WIN_START = 12,
    parameter int MASK_W    = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rx_valid,
    input  logic                      rx_sof,
    output logic                      in_win_o,
    output logic [$clog2(MASK_W)-1:0] win_idx_o
);
    localparam int WIN_END = WIN_START + MASK_W;
    localparam int OFF_W   = $clog2(WIN_END) + 1;
    localparam int IDX_W   = $clog2(MASK_W);

    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] cur_off;
    logic [OFF_W-1:0] rel_off;

    assign cur_off   = rx_sof ? '0 : off_q;
    assign rel_off   = cur_off - OFF_W'(WIN_START);
    assign in_win_o  = (cur_off >= OFF_W'(WIN_START)) && (cur_off < OFF_W'(WIN_END));
    assign win_idx_o = rel_off[IDX_W-1:0];

    // Advance the offset for each accepted byte, holding it at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (rx_valid) begin
            off_q <= (cur_off >= OFF_W'(WIN_END)) ? OFF_W'(WIN_END) : cur_off + 1'b1;
        end
    end
endmodule

// File: rtl/wkp_lane.sv
// One pattern lane: folds the masked bytes into CRC-8 and judges the frame
// at its end byte. Assumes the window position comes from wkp_offset.
module wkp_lane
    import wkp_pkg::*;
#(
    parameter int    MASK_W   = 64,
    parameter byte_t CRC_POLY = 8'h07
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rx_valid,
    input  byte_t                     rx_data,
    input  logic                      rx_sof,
    input  logic                      rx_eof,
    input  logic                      rx_good,
    input  logic                      in_win,
    input  logic [$clog2(MASK_W)-1:0] win_idx,
    input  logic [MASK_W-1:0]         mask_i,
    input  byte_t                     ref_i,
    output logic                      hit_o,
    output logic                      match_o
);
    byte_t crc_q;
    byte_t crc_base;
    byte_t crc_nxt;
    logic  take;

    assign take     = rx_valid && in_win && mask_i[win_idx];
    assign crc_base = rx_sof ? '0 : crc_q;
    assign crc_nxt  = take ? crc8_step(crc_base, rx_data, CRC_POLY) : crc_base;
    assign hit_o    = rx_valid && rx_eof && rx_good && (|mask_i) && (crc_nxt == ref_i);

    // Keep the running CRC across the bytes of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '0;
        else if (rx_valid) crc_q <= crc_nxt;
    end

    // Register the frame verdict as a one-cycle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) match_o <= 1'b0;
        else match_o <= hit_o;
    end

    // R6
    match_on_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(rx_valid && rx_eof && rx_good));

    // R5
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(|mask_i));
endmodule

// File: rtl/wkp_matcher.sv
// Wakeup pattern matcher top. It runs NUM_PAT CRC lanes in parallel over
// one receive byte stream. It reports per-pattern matches and a gated wake
// pulse one cycle after each end byte.
module wkp_matcher
    import wkp_pkg::*;
#(
    parameter int    NUM_PAT   = 8,
    parameter int    MASK_W    = 64,
    parameter int    WIN_START = 12,
    parameter byte_t CRC_POLY  = 8'h07,
    localparam int   ADDR_W    = $clog2(NUM_PAT) + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wake_en,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    input  logic               rx_sof,
    input  logic               rx_eof,
    input  logic               rx_good,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [NUM_PAT-1:0] match_o,
    output logic               wake_o
);
    localparam int IDX_W = $clog2(MASK_W);

    logic [NUM_PAT-1:0][MASK_W-1:0] masks;
    byte_t [NUM_PAT-1:0]            refs;
    logic                           in_win;
    logic [IDX_W-1:0]               win_idx;
    logic [NUM_PAT-1:0]             hits;

    wkp_cfg_regs #(.NUM_PAT(NUM_PAT), .MASK_W(MASK_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mask_o(masks), .ref_o(refs)
    );

    wkp_offset #(.WIN_START(WIN_START), .MASK_W(MASK_W)) u_off (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .in_win_o(in_win), .win_idx_o(win_idx)
    );

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_lane
        wkp_lane #(.MASK_W(MASK_W), .CRC_POLY(CRC_POLY)) u_lane (
            .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
            .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good),
            .in_win(in_win), .win_idx(win_idx), .mask_i(masks[g]),
            .ref_i(refs[g]), .hit_o(hits[g]), .match_o(match_o[g])
        );
    end

    // Raise the wake pulse for any match when waking is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_o <= 1'b0;
        else wake_o <= wake_en && (|hits);
    end

    // R9
    wake_has_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (|match_o));

    // R9
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(wake_en));
endmodule

// File: tb/sim_wkp_matcher.sv
`timescale 1ns/1ps
module sim_wkp_matcher;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake_en = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_sof = 1'b0;
    logic       rx_eof = 1'b0;
    logic       rx_good = 1'b0;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] match_o;
    logic       wake_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0]  frm [0:127];
    logic [63:0] m_mask [0:7];
    logic [7:0]  m_ref [0:7];
    logic [7:0]  got_m, got_m2;
    logic        got_w, got_w2;

    always #10 clk = ~clk;

    wkp_matcher u0 (
        .clk(clk), .rst_n(rst_n), .wake_en(wake_en), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .match_o(match_o), .wake_o(wake_o)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] step(input logic [7:0] c_in, input logic [7:0] d);
        logic [7:0] c = c_in ^ d;
        for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        return c;
    endfunction

    function automatic logic [7:0] crc_of(input int p, input int len);
        logic [7:0] c = 8'h00;
        for (int off = 12; off < 76; off++)
            if (off < len && m_mask[p][off-12]) c = step(c, frm[off]);
        return c;
    endfunction

    function automatic logic [7:0] exp_vec(input int len, input bit good);
        logic [7:0] v = '0;
        for (int p = 0; p < 8; p++)
            v[p] = good && (m_mask[p] != 0) && (crc_of(p, len) == m_ref[p]);
        return v;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 128; i++) frm[i] = 8'(i * 37 + seed * 11 + 5);
    endtask

    // Register write with the model following the R4 address map.
    task automatic wr(input int p, input int idx, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {3'(p), 4'(idx)}; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < 8) m_mask[p][idx*8 +: 8] = v;
        else if (idx == 8) m_ref[p] = v;
        else if (idx == 9) m_mask[p][7:0] = v;
    endtask

    task automatic program_ref(input int p, input int len);
        wr(p, 8, crc_of(p, len));
    endtask

    task automatic send(input int len, input bit good, input bit do_eof);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = frm[i];
            rx_sof = (i == 0); rx_eof = do_eof && (i == len - 1);
            rx_good = good;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
        got_m = match_o; got_w = wake_o;
        @(negedge clk);
        got_m2 = match_o; got_w2 = wake_o;
    endtask

    task automatic t_reset;
        check(match_o == 8'h00, "R1 match after reset", match_o, 8'h00);
        check(wake_o == 1'b0, "R1 wake after reset", {7'b0, wake_o}, 8'h00);
    endtask

    task automatic t_single;
        logic [7:0] e;
        fill(1);
        wr(0, 0, 8'hFF);
        program_ref(0, 80);
        e = exp_vec(80, 1);
        send(80, 1, 1);
        check(got_m == 8'h01 && e == 8'h01, "R2 single pattern", got_m, 8'h01);
        check(got_w == 1'b1, "R9 wake on match", {7'b0, got_w}, 8'h01);
        check(got_m2 == 8'h00 && got_w2 == 1'b0, "R11 one-cycle pulse", got_m2, 8'h00);
    endtask

    task automatic t_parallel;
        for (int p = 0; p < 8; p++) begin
            for (int b = 0; b < 8; b++) wr(p, b, 8'(p * 29 + b * 53 + 1));
            wr(p, 8, crc_of(p, 80) ^ ((p % 2 == 1) ? 8'h5A : 8'h00));
        end
        send(80, 1, 1);
        check(got_m == 8'h55 && exp_vec(80, 1) == 8'h55, "R8 independent patterns", got_m, 8'h55);
    endtask

    task automatic t_outside;
        for (int i = 0; i < 12; i++) frm[i] = ~frm[i];
        for (int i = 76; i < 80; i++) frm[i] = frm[i] ^ 8'h3C;
        send(80, 1, 1);
        check(got_m == 8'h55, "R3 bytes outside window ignored", got_m, 8'h55);
        frm[75] = frm[75] ^ 8'h01;
        send(80, 1, 1);
        check(got_m == exp_vec(80, 1), "R3 last window byte counts", got_m, exp_vec(80, 1));
        frm[75] = frm[75] ^ 8'h01;
    endtask

    task automatic t_bad;
        send(80, 0, 1);
        check(got_m == 8'h00, "R6 bad frame", got_m, 8'h00);
        check(got_w == 1'b0, "R6 no wake on bad frame", {7'b0, got_w}, 8'h00);
    endtask

    task automatic t_zero;
        for (int b = 0; b < 8; b++) wr(0, b, 8'h00);
        wr(0, 8, 8'h00);
        send(80, 1, 1);
        check(got_m == 8'h54, "R5 zero mask never matches", got_m, 8'h54);
    endtask

    task automatic t_short;
        for (int p = 1; p < 8; p++) program_ref(p, 20);
        send(20, 1, 1);
        check(got_m == 8'hFE && exp_vec(20, 1) == 8'hFE, "R7 short frame", got_m, 8'hFE);
    endtask

    task automatic t_gate;
        wake_en = 1'b0;
        send(20, 1, 1);
        check(got_m == 8'hFE, "R9 match without enable", got_m, 8'hFE);
        check(got_w == 1'b0, "R9 wake gated off", {7'b0, got_w}, 8'h00);
        wake_en = 1'b1;
    endtask

    task automatic t_alias;
        logic [7:0] e;
        wr(1, 9, 8'hC3);
        program_ref(1, 20);
        wr(2, 12, 8'hFF);
        wr(2, 15, 8'h00);
        e = exp_vec(20, 1);
        send(20, 1, 1);
        check(got_m == e && e[2:1] == 2'b11, "R4 alias and ignored indices", got_m, e);
    endtask

    task automatic t_restart;
        logic [7:0] e;
        e = exp_vec(20, 1);
        fill(9);
        send(30, 1, 0);
        check(got_m == 8'h00, "R10 no verdict without end byte", got_m, 8'h00);
        fill(1);
        send(20, 1, 1);
        check(got_m == e && got_w == 1'b1, "R10 restart on start byte", got_m, e);
    endtask

    initial begin
        for (int p = 0; p < 8; p++) begin m_mask[p] = '0; m_ref[p] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_parallel();
        t_outside();
        t_bad();
        t_zero();
        t_short();
        t_gate();
        t_alias();
        t_restart();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule